// File: doc/BRIEF.md
# Priority-Based Multi-Function Pin Multiplexer

The block sits between a set of SoC peripherals and seven shared pads. Each pad can carry several peripheral signals. The choice between them is set by a small register file: five writable pin-control words and two read-only strap words. The strap words are loaded from strap pins while reset is held.

For every pad, each priority level has an enable condition. A condition is an OR of AND terms, and each term compares a masked register field, shifted down to bit 0, against a constant. The highest-priority level whose condition is true drives the pad. When no level is true, the pad carries its fallback signal. The block outputs a 3-bit select code for each pad and routes the chosen source bit to that pad. Selection is combinational from the register contents, so a register write takes effect in the cycle after the write edge.

Top module: `pinmux_top`

## Requirements
- R1: After reset, every pin-control register reads as zero. Pad 3's level-1 condition then holds because strap A bit 19 is 0. Every other pad selects its fallback.
- R2: A write with `we_i` high sets the addressed control register at the clock edge: offset 0x3C, 0x80, 0x84, 0x90 or 0xA4. The read data `rdata_o` shows the register contents combinationally for the current `addr_i`.
- R3: An offset that maps to no register reads as zero. A write to such an offset changes no register and no select code.
- R4: Strap A (offset 0x70) and strap B (offset 0xD0) take the values on `strap_a_i` and `strap_b_i` while `rst_ni` is low. Bus writes to them are ignored.
- R5: `sel_o[3p+2:3p]` for pad p is the winning level, 0 to 4, or 7 when no level is active. `pad_o[p]` equals `src_i[6p+s]`, where s is the select code, or s is 5 when the code is 7.
- R6: When the conditions of more than one level are true, the lowest-numbered level wins. Pad 1: level 0 is 0x90[22]=1 and level 1 is 0x80[4]=1. Pad 3: level 0 is 0x80[25]=1.
- R7: Pad 0 takes level 0 when 0x80[0]=1. Pad 2 takes level 0 when 0x80[12]=1 or strap A[14]=1, so either term is enough.
- R8: Pad 3 takes level 1 when 0xA4[12]=1 or strap A[14+5]=0, which is bit 19. With the strap bit at 0, the level cannot be turned off by writes.
- R9: Pad 4 needs 0x3C[3]=1 and 0x80[15]=1 for either of its levels. Level 0 also needs 0x90[31]=0 and level 1 needs 0x90[31]=1. If any one of the shared terms is missing, the pad falls back.
- R10: Pad 5 takes level 0 when the field 0x90[5:4] is 1, 2 or 3 and 0x84[17]=1. It takes level 1 when 0x84[17]=1 alone.
- R11: Pad 6 takes level 0 only when 0x90[5:4] equals 3 and 0x84[22]=1. It takes level 1 when 0x84[22]=1 and the field has any other value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; the strap words load while it is low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 8 | Word-aligned byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` |
| strap_a_i | input | 32 | Strap pins for strap A |
| strap_b_i | input | 32 | Strap pins for strap B |
| src_i | input | 42 | Peripheral sources, 6 per pad; slot 5 is the fallback |
| sel_o | output | 21 | Select code per pad, 3 bits each |
| pad_o | output | 7 | Pad outputs |

## Verification
Strap-dependent behaviour is the hardest part to reach, because the strap words can only change through a reset. The bench therefore applies reset again with new strap pin values. It then shows that bus writes to the strap offsets leave both the read-back value and the strap-driven selections unchanged. A table of register settings covers the field-equality corners on pads 4 to 6: a missing shared term, field values 1, 2 and 3, and field value 3 compared with the others.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
  localparam int NUM_PINS = 7;
  localparam int NUM_LVL  = 5;
  localparam int SLOTS    = NUM_LVL + 1;
  localparam int SEL_W    = $clog2(SLOTS);
  localparam int DW       = 32;

  localparam logic [7:0] OFS_RST  = 8'h3C;
  localparam logic [7:0] OFS_STA  = 8'h70;
  localparam logic [7:0] OFS_CTA  = 8'h80;
  localparam logic [7:0] OFS_CTB  = 8'h84;
  localparam logic [7:0] OFS_CTC  = 8'h90;
  localparam logic [7:0] OFS_CTD  = 8'hA4;
  localparam logic [7:0] OFS_STB  = 8'hD0;

  typedef struct packed {
    logic [DW-1:0] rst_ctl;
    logic [DW-1:0] ctl_a;
    logic [DW-1:0] ctl_b;
    logic [DW-1:0] ctl_c;
    logic [DW-1:0] ctl_d;
    logic [DW-1:0] strap_a;
    logic [DW-1:0] strap_b;
  } pm_regs_t;

  // masked field, right-aligned by lowest set mask bit, compared to val
  function automatic logic field_eq(logic [DW-1:0] word, logic [DW-1:0] mask,
                                    logic [DW-1:0] val);
    logic [DW-1:0] f;
    int sh;
    sh = 0;
    for (int i = DW - 1; i >= 0; i--) if (mask[i]) sh = i;
    f = (word & mask) >> sh;
    return f == val;
  endfunction
endpackage

// File: rtl/pinmux_regs.sv
module pinmux_regs
  import pinmux_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [DW-1:0] strap_a_i,
  input  logic [DW-1:0] strap_b_i,
  output logic [DW-1:0] rdata_o,
  output pm_regs_t      regs_o
);
  pm_regs_t r_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      r_q.rst_ctl <= '0;
      r_q.ctl_a   <= '0;
      r_q.ctl_b   <= '0;
      r_q.ctl_c   <= '0;
      r_q.ctl_d   <= '0;
      r_q.strap_a <= strap_a_i;
      r_q.strap_b <= strap_b_i;
    end else if (we_i) begin
      case (addr_i)
        AW'(OFS_RST): r_q.rst_ctl <= wdata_i;
        AW'(OFS_CTA): r_q.ctl_a   <= wdata_i;
        AW'(OFS_CTB): r_q.ctl_b   <= wdata_i;
        AW'(OFS_CTC): r_q.ctl_c   <= wdata_i;
        AW'(OFS_CTD): r_q.ctl_d   <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (addr_i)
      AW'(OFS_RST): rdata_o = r_q.rst_ctl;
      AW'(OFS_STA): rdata_o = r_q.strap_a;
      AW'(OFS_CTA): rdata_o = r_q.ctl_a;
      AW'(OFS_CTB): rdata_o = r_q.ctl_b;
      AW'(OFS_CTC): rdata_o = r_q.ctl_c;
      AW'(OFS_CTD): rdata_o = r_q.ctl_d;
      AW'(OFS_STB): rdata_o = r_q.strap_b;
      default:      rdata_o = '0;
    endcase
  end

  assign regs_o = r_q;

  assert_ctl_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == AW'(OFS_CTA)) |=> r_q.ctl_a == $past(wdata_i));

  assert_strap_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(r_q.strap_a) && $stable(r_q.strap_b));
endmodule

// File: rtl/pinmux_expr.sv
module pinmux_expr
  import pinmux_pkg::*;
(
  input  pm_regs_t                         regs_i,
  output logic [NUM_PINS-1:0][NUM_LVL-1:0] hit_o
);
  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [DW-1:0] ZERO = '0;

  logic vid_field_any, vid_field_full;

  always_comb begin
    vid_field_any = field_eq(regs_i.ctl_c, DW'(32'h30), DW'(1))
                  | field_eq(regs_i.ctl_c, DW'(32'h30), DW'(2))
                  | field_eq(regs_i.ctl_c, DW'(32'h30), DW'(3));
    vid_field_full = field_eq(regs_i.ctl_c, DW'(32'h30), DW'(3));

    hit_o = '0;
    // pad 0
    hit_o[0][0] = field_eq(regs_i.ctl_a, DW'(32'h1), ONE);
    // pad 1
    hit_o[1][0] = field_eq(regs_i.ctl_c, DW'(32'h0040_0000), ONE);
    hit_o[1][1] = field_eq(regs_i.ctl_a, DW'(32'h10), ONE);
    // pad 2: register term OR strap term
    hit_o[2][0] = field_eq(regs_i.ctl_a, DW'(32'h1000), ONE)
                | field_eq(regs_i.strap_a, DW'(32'h4000), ONE);
    // pad 3
    hit_o[3][0] = field_eq(regs_i.ctl_a, DW'(32'h0200_0000), ONE);
    hit_o[3][1] = field_eq(regs_i.ctl_d, DW'(32'h1000), ONE)
                | field_eq(regs_i.strap_a, DW'(32'h0008_0000), ZERO);
    // pad 4: shared AND terms, split by one bit
    hit_o[4][0] = field_eq(regs_i.rst_ctl, DW'(32'h8), ONE)
                & field_eq(regs_i.ctl_a, DW'(32'h8000), ONE)
                & field_eq(regs_i.ctl_c, DW'(32'h8000_0000), ZERO);
    hit_o[4][1] = field_eq(regs_i.rst_ctl, DW'(32'h8), ONE)
                & field_eq(regs_i.ctl_a, DW'(32'h8000), ONE)
                & field_eq(regs_i.ctl_c, DW'(32'h8000_0000), ONE);
    // pad 5
    hit_o[5][0] = vid_field_any & field_eq(regs_i.ctl_b, DW'(32'h0002_0000), ONE);
    hit_o[5][1] = field_eq(regs_i.ctl_b, DW'(32'h0002_0000), ONE);
    // pad 6
    hit_o[6][0] = vid_field_full & field_eq(regs_i.ctl_b, DW'(32'h0040_0000), ONE);
    hit_o[6][1] = field_eq(regs_i.ctl_b, DW'(32'h0040_0000), ONE);
  end
endmodule

// File: rtl/pinmux_prio.sv
module pinmux_prio
  import pinmux_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LVL-1:0]   hit_i,
  input  logic [SLOTS-1:0]     src_i,
  output logic [SEL_W-1:0]     sel_o,
  output logic                 pad_o
);
  localparam logic [SEL_W-1:0] OTHER = '1;

  always_comb begin
    sel_o = OTHER;
    for (int l = NUM_LVL - 1; l >= 0; l--) if (hit_i[l]) sel_o = SEL_W'(l);
  end

  assign pad_o = (sel_o == OTHER) ? src_i[SLOTS-1] : src_i[sel_o];

  assert_winner_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o != OTHER) |-> (hit_i[sel_o] &&
      ((hit_i & NUM_LVL'((1 << sel_o) - 1)) == '0)));

  assert_fallback_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o == OTHER) |-> (hit_i == '0));
endmodule

// File: rtl/pinmux_top.sv
module pinmux_top
  import pinmux_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [AW-1:0]             addr_i,
  input  logic [DW-1:0]             wdata_i,
  output logic [DW-1:0]             rdata_o,
  input  logic [DW-1:0]             strap_a_i,
  input  logic [DW-1:0]             strap_b_i,
  input  logic [NUM_PINS*SLOTS-1:0] src_i,
  output logic [NUM_PINS*SEL_W-1:0] sel_o,
  output logic [NUM_PINS-1:0]       pad_o
);
  pm_regs_t                         regs;
  logic [NUM_PINS-1:0][NUM_LVL-1:0] hit;

  pinmux_regs #(.AW(AW)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .strap_a_i, .strap_b_i,
    .rdata_o, .regs_o(regs)
  );

  pinmux_expr u_expr (.regs_i(regs), .hit_o(hit));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    pinmux_prio u_prio (
      .clk_i, .rst_ni,
      .hit_i(hit[p]),
      .src_i(src_i[p*SLOTS +: SLOTS]),
      .sel_o(sel_o[p*SEL_W +: SEL_W]),
      .pad_o(pad_o[p])
    );
  end
endmodule

// File: tb/pinmux_top_bench.sv
module pinmux_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 7;
  localparam int VW = 5*32 + 21;

  logic        clk = 0, rst_ni = 0, we = 0;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata, strap_a = 0, strap_b = 0;
  logic [41:0] src = 0;
  logic [20:0] sel;
  logic [6:0]  pad;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pinmux_top u_pinmux_top (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .strap_a_i(strap_a), .strap_b_i(strap_b), .src_i(src),
    .sel_o(sel), .pad_o(pad)
  );

  // {rst_ctl, ctl_a, ctl_b, ctl_c, ctl_d, sel codes pad6..pad0}
  localparam logic [VW-1:0] VEC [7] = '{
    {32'h0, 32'h0, 32'h0, 32'h0, 32'h0,
     3'd7, 3'd7, 3'd7, 3'd1, 3'd7, 3'd7, 3'd7},
    {32'h0, 32'h0000_1011, 32'h0, 32'h0040_0000, 32'h0,
     3'd7, 3'd7, 3'd7, 3'd1, 3'd0, 3'd0, 3'd0},
    {32'h8, 32'h0200_8000, 32'h0, 32'h8000_0000, 32'h0,
     3'd7, 3'd7, 3'd1, 3'd0, 3'd7, 3'd7, 3'd7},
    {32'h8, 32'h0000_8000, 32'h0042_0000, 32'h10, 32'h0,
     3'd1, 3'd0, 3'd0, 3'd1, 3'd7, 3'd7, 3'd7},
    {32'h0, 32'h0000_8000, 32'h0042_0000, 32'h30, 32'h0,
     3'd0, 3'd0, 3'd7, 3'd1, 3'd7, 3'd7, 3'd7},
    {32'h0, 32'h10, 32'h0002_0000, 32'h20, 32'h0,
     3'd7, 3'd0, 3'd7, 3'd1, 3'd7, 3'd1, 3'd7},
    {32'h0, 32'h0, 32'h0002_0000, 32'h0, 32'h1000,
     3'd7, 3'd1, 3'd7, 3'd1, 3'd7, 3'd7, 3'd7}
  };

  function automatic logic [6:0] exp_pad(logic [20:0] s, logic [41:0] sv);
    logic [6:0] r;
    for (int p = 0; p < NP; p++) begin
      int c;
      c = int'(s[p*3 +: 3]);
      r[p] = sv[p*6 + ((c == 7) ? 5 : c)];
    end
    return r;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd_check(string req, logic [7:0] a, logic [31:0] exp);
    addr = a; #1;
    check(req, 64'(rdata), 64'(exp));
  endtask

  task automatic do_reset();
    rst_ni = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    strap_b = 32'hA5A5_0F0F;
    do_reset();
    // R1 reset state
    rd_check("R1", 8'h80, 32'h0);
    rd_check("R1", 8'h90, 32'h0);
    check("R1", 64'(sel), 64'({3'd7, 3'd7, 3'd7, 3'd1, 3'd7, 3'd7, 3'd7}));

    // table walk: R5..R11
    for (int v = 0; v < 7; v++) begin
      logic [VW-1:0] e;
      e = VEC[v];
      wr(8'h3C, e[VW-1 -: 32]);
      wr(8'h80, e[VW-33 -: 32]);
      wr(8'h84, e[VW-65 -: 32]);
      wr(8'h90, e[VW-97 -: 32]);
      wr(8'hA4, e[VW-129 -: 32]);
      check("R6/R7/R9/R10/R11 sel", 64'(sel), 64'(e[20:0]));
      src = 42'h2AA_AAAA_AAAA ^ (42'(v) * 42'h1_2345_6789); #1;
      check("R5 pad", 64'(pad), 64'(exp_pad(e[20:0], src)));
      src = ~src; #1;
      check("R5 pad inverted", 64'(pad), 64'(exp_pad(e[20:0], src)));
    end

    // R2 read back
    wr(8'h84, 32'hDEAD_BEEF);
    rd_check("R2", 8'h84, 32'hDEAD_BEEF);
    rd_check("R2", 8'hA4, 32'h1000);

    // R3 unmapped offset
    wr(8'h80, 32'h0);
    wr(8'h84, 32'h0);
    wr(8'h44, 32'hFFFF_FFFF);
    rd_check("R3", 8'h44, 32'h0);
    rd_check("R3", 8'h80, 32'h0);
    check("R3 sel", 64'(sel), 64'({3'd7, 3'd7, 3'd7, 3'd1, 3'd7, 3'd7, 3'd7}));

    // R4/R7/R8 strap reload
    strap_a = 32'h0008_4000;
    do_reset();
    rd_check("R4", 8'h70, 32'h0008_4000);
    rd_check("R4", 8'hD0, 32'hA5A5_0F0F);
    wr(8'h70, 32'h0);
    wr(8'hD0, 32'h0);
    rd_check("R4", 8'h70, 32'h0008_4000);
    rd_check("R4", 8'hD0, 32'hA5A5_0F0F);
    check("R7 strap term", 64'(sel[8:6]), 64'(3'd0));
    check("R8 strap set", 64'(sel[11:9]), 64'(3'd7));
    wr(8'hA4, 32'h1000);
    check("R8 reg term", 64'(sel[11:9]), 64'(3'd1));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule